// File: doc/BRIEF.md
# Parity-Mapped Skip Address Generator

This block walks a physical address range and emits only the cache-block addresses that belong to one processing unit and one block group. The memory system spreads blocks with an XOR mapping. Each bit of the combined identifier (unit bits first, then group bits) is the parity of the address bits picked out by its own mask. Addresses are counted in cache blocks, so a plain increment advances to the next block.

A near-memory engine loads a range, the target identifiers and the masks, then pulses `start`. It draws addresses through a valid/ready pair until `done` rises. The fast path never scans the addresses in between. From any matching address it steps a counter made of the bits that fix no identifier. The carry skips over the bits that do fix one, and those bits are then rewritten from the parity of the higher bits. One correction cycle yields the next match. A naive mode, selected at launch, scans one block per cycle instead. It emits the same sequence and is kept for comparison.

Masks must meet one rule. Each mask is nonzero. Its lowest set bit (its pivot) is distinct from the pivot of every other mask, and no other mask has that bit set. Column-index bits are simply left out of the group masks.

Top module: `xor_skip_agen`

## Requirements
- R1: During and right after reset, `addr_valid` and `done` are low.
- R2: Every emitted address satisfies parity(addr & mask k) == target bit k for every k. Here k runs over unit bits 0..NID-1 (mask k at `unit_masks[k*AW +: AW]`) and then group bits 0..NGRP-1 (mask at `group_masks[k*AW +: AW]`).
- R3: The emitted sequence is exactly the set of matching addresses in [start, end], in strictly ascending order. A matching start address is the first one emitted.
- R4: Naive mode and fast mode emit identical sequences for the same configuration.
- R5: While `addr_valid` is high and `addr_ready` is low, `addr_out` holds and `addr_valid` stays high. The output advances only on a handshake.
- R6: `done` rises once no matching address is left in range, including when start > end or when the next candidate would pass the top of the address space (no wraparound). It stays high with `addr_valid` low until the next accepted `start`.
- R7: In fast mode, with `addr_ready` held high, `addr_valid` is never low for more than 3 consecutive cycles between launch and `done`. This fits inside a 4-cycle burst window.
- R8: A `start` pulse while a walk is running is ignored. The running sequence is unaffected, including by changes to the range and configuration inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, accepted when idle or done |
| naive_mode | input | 1 | 1 = scan one block per cycle, 0 = pivot-skip path |
| start_addr | input | AW | First block address of the range |
| end_addr | input | AW | Last block address of the range (inclusive) |
| unit_id | input | NID | Target unit identifier |
| group_id | input | NGRP | Target block-group identifier |
| unit_masks | input | NID*AW | Parity masks for unit bits, bit k at [k*AW +: AW] |
| group_masks | input | NGRP*AW | Parity masks for group bits, bit k at [k*AW +: AW] |
| addr_valid | output | 1 | Address offered |
| addr_ready | input | 1 | Consumer accepts the offered address |
| addr_out | output | AW | Offered block address |
| done | output | 1 | Walk complete |

## Verification
The bench builds the block with AW=12, NID=2 and NGRP=1. This lets a reference model scan the full 4096-block space for every run. It also brings the top-of-space edge, where a naive increment would wrap, within easy reach. With three masks, the pivot positions and the high-order taps can be drawn at random, including adjacent bits that feed one identifier bit and runs of pivots that the carry must cross in one step. The same drawn configurations are run through both modes with random backpressure, and the two sequences are compared.

// File: rtl/agen_pkg.sv
`timescale 1ns/1ps
package agen_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEED,
    ST_FILL,
    ST_SCAN,
    ST_OFFER,
    ST_DONE
  } agen_state_e;
endpackage

// File: rtl/agen_id_eval.sv
`timescale 1ns/1ps
// Parity of the masked address, one result bit per identifier bit.
module agen_id_eval #(
  parameter int AW = 26,
  parameter int K  = 5
) (
  input  logic [AW-1:0]   addr,
  input  logic [K*AW-1:0] masks,
  output logic [K-1:0]    ids
);
  for (genvar k = 0; k < K; k++) begin : g_bit
    assign ids[k] = ^(addr & masks[k*AW +: AW]);
  end
endmodule

// File: rtl/agen_pivot_fill.sv
`timescale 1ns/1ps
// Rewrites each mask's lowest (pivot) bit so that the mask parity hits its
// target. Non-pivot bits pass through unchanged.
module agen_pivot_fill #(
  parameter int AW = 26,
  parameter int K  = 5
) (
  input  logic [AW-1:0]   base_addr,
  input  logic [K*AW-1:0] masks,
  input  logic [K-1:0]    target,
  output logic [AW-1:0]   pivots,
  output logic [AW-1:0]   filled
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] lead [K];
  logic [AW-1:0] setb [K];

  for (genvar k = 0; k < K; k++) begin : g_row
    logic [AW-1:0] mk;
    logic [AW-1:0] rest;
    logic          par;
    assign mk      = masks[k*AW +: AW];
    assign lead[k] = mk & (~mk + ONE);
    assign rest    = mk & ~lead[k];
    assign par     = ^(base_addr & rest);
    assign setb[k] = (target[k] ^ par) ? lead[k] : '0;
  end

  logic [AW-1:0] acc;
  always_comb begin
    pivots = '0;
    acc    = '0;
    for (int k = 0; k < K; k++) begin
      pivots = pivots | lead[k];
      acc    = acc | setb[k];
    end
    filled = (base_addr & ~pivots) | acc;
  end
endmodule

// File: rtl/xor_skip_agen.sv
`timescale 1ns/1ps
module xor_skip_agen
  import agen_pkg::*;
#(
  parameter int AW   = 26,
  parameter int NID  = 3,
  parameter int NGRP = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 naive_mode,
  input  logic [AW-1:0]        start_addr,
  input  logic [AW-1:0]        end_addr,
  input  logic [NID-1:0]       unit_id,
  input  logic [NGRP-1:0]      group_id,
  input  logic [NID*AW-1:0]    unit_masks,
  input  logic [NGRP*AW-1:0]   group_masks,
  output logic                 addr_valid,
  input  logic                 addr_ready,
  output logic [AW-1:0]        addr_out,
  output logic                 done
);
  localparam int K  = NID + NGRP;
  localparam int MW = K * AW;
  localparam logic [AW:0] INC1 = {{AW{1'b0}}, 1'b1};

  agen_state_e state_q, state_d;
  logic          mode_q;
  logic [AW-1:0] hi_q;
  logic [MW-1:0] masks_q;
  logic [K-1:0]  tgt_q;
  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] out_q, out_d;
  logic          valid_q, valid_d;
  logic          done_q, done_d;
  logic          launch;

  logic [AW-1:0] pivots, filled;
  logic [K-1:0]  ids;

  agen_pivot_fill #(.AW(AW), .K(K)) u_fill (
    .base_addr (base_q),
    .masks     (masks_q),
    .target    (tgt_q),
    .pivots    (pivots),
    .filled    (filled)
  );

  agen_id_eval #(.AW(AW), .K(K)) u_ids (
    .addr  (base_q),
    .masks (masks_q),
    .ids   (ids)
  );

  // Highest bit where the pivot-corrected seed departs from the start
  // address; everything below it is free to be reset or saturated.
  logic [AW-1:0] diff, smear, below;
  always_comb begin
    diff = filled ^ base_q;
    smear[AW-1] = diff[AW-1];
    for (int i = AW - 2; i >= 0; i--) begin
      smear[i] = smear[i+1] | diff[i];
    end
    below = smear >> 1;
  end

  // Increments with carry-out; pivots forced to one so the carry crosses them.
  logic [AW:0] sum_seed, sum_fast, sum_naive, sum_scan;
  always_comb begin
    sum_seed  = {1'b0, base_q | below | pivots} + INC1;
    sum_fast  = {1'b0, out_q | pivots} + INC1;
    sum_naive = {1'b0, out_q} + INC1;
    sum_scan  = {1'b0, base_q} + INC1;
  end

  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    out_d   = out_q;
    valid_d = valid_q;
    done_d  = done_q;
    launch  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          launch  = 1'b1;
          base_d  = start_addr;
          done_d  = 1'b0;
          state_d = naive_mode ? ST_SCAN : ST_SEED;
        end
      end
      ST_SEED: begin
        if (filled >= base_q) begin
          base_d  = base_q & ~below;
          state_d = ST_FILL;
        end else if (sum_seed[AW]) begin
          done_d  = 1'b1;
          state_d = ST_DONE;
        end else begin
          base_d  = sum_seed[AW-1:0];
          state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        if (filled > hi_q) begin
          done_d  = 1'b1;
          state_d = ST_DONE;
        end else begin
          out_d   = filled;
          valid_d = 1'b1;
          state_d = ST_OFFER;
        end
      end
      ST_SCAN: begin
        if (base_q > hi_q) begin
          done_d  = 1'b1;
          state_d = ST_DONE;
        end else if (ids == tgt_q) begin
          out_d   = base_q;
          valid_d = 1'b1;
          state_d = ST_OFFER;
        end else if (sum_scan[AW]) begin
          done_d  = 1'b1;
          state_d = ST_DONE;
        end else begin
          base_d  = sum_scan[AW-1:0];
        end
      end
      ST_OFFER: begin
        if (addr_ready) begin
          valid_d = 1'b0;
          if (mode_q) begin
            if (sum_naive[AW]) begin
              done_d  = 1'b1;
              state_d = ST_DONE;
            end else begin
              base_d  = sum_naive[AW-1:0];
              state_d = ST_SCAN;
            end
          end else begin
            if (sum_fast[AW]) begin
              done_d  = 1'b1;
              state_d = ST_DONE;
            end else begin
              base_d  = sum_fast[AW-1:0];
              state_d = ST_FILL;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      hi_q    <= '0;
      masks_q <= '0;
      tgt_q   <= '0;
      base_q  <= '0;
      out_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      out_q   <= out_d;
      valid_q <= valid_d;
      done_q  <= done_d;
      if (launch) begin
        mode_q  <= naive_mode;
        hi_q    <= end_addr;
        masks_q <= {group_masks, unit_masks};
        tgt_q   <= {group_id, unit_id};
      end
    end
  end

  assign addr_valid = valid_q;
  assign addr_out   = out_q;
  assign done       = done_q;
endmodule

// File: rtl/agen_skip_chk.sv
`timescale 1ns/1ps
module agen_skip_chk #(
  parameter int AW   = 26,
  parameter int NID  = 3,
  parameter int NGRP = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               naive_mode,
  input logic [AW-1:0]      start_addr,
  input logic [AW-1:0]      end_addr,
  input logic [NID-1:0]     unit_id,
  input logic [NGRP-1:0]    group_id,
  input logic [NID*AW-1:0]  unit_masks,
  input logic [NGRP*AW-1:0] group_masks,
  input logic               addr_valid,
  input logic               addr_ready,
  input logic [AW-1:0]      addr_out,
  input logic               done
);
  localparam int K = NID + NGRP;

  logic            run_q, mode_c, have_q;
  logic [AW-1:0]   lo_c, hi_c, last_q;
  logic [K*AW-1:0] mk_c;
  logic [K-1:0]    tgt_c, seen_ids;
  logic [2:0]      gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      mode_c <= 1'b0;
      have_q <= 1'b0;
      lo_c   <= '0;
      hi_c   <= '0;
      last_q <= '0;
      mk_c   <= '0;
      tgt_c  <= '0;
      gap_q  <= '0;
    end else begin
      if (start && (!run_q || done)) begin
        run_q  <= 1'b1;
        mode_c <= naive_mode;
        lo_c   <= start_addr;
        hi_c   <= end_addr;
        mk_c   <= {group_masks, unit_masks};
        tgt_c  <= {group_id, unit_id};
        have_q <= 1'b0;
        gap_q  <= '0;
      end else begin
        if (done) run_q <= 1'b0;
        if (addr_valid && addr_ready) begin
          last_q <= addr_out;
          have_q <= 1'b1;
        end
        if (run_q && !mode_c && !addr_valid && !done) begin
          if (gap_q != 3'd7) gap_q <= gap_q + 3'd1;
        end else begin
          gap_q <= '0;
        end
      end
    end
  end

  always_comb begin
    for (int k = 0; k < K; k++) begin
      seen_ids[k] = ^(addr_out & mk_c[k*AW +: AW]);
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    $fell(rst) |-> !addr_valid && !done);

  a_r2_id_match: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> seen_ids == tgt_c);

  a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> (addr_out >= lo_c) && (addr_out <= hi_c));

  a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && have_q) |-> addr_out > last_q);

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !addr_ready) |=> addr_valid && $stable(addr_out));

  a_r6_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !addr_valid);

  a_r7_gap_bound: assert property (@(posedge clk) disable iff (rst)
    gap_q <= 3'd3);
endmodule

bind xor_skip_agen agen_skip_chk #(.AW(AW), .NID(NID), .NGRP(NGRP)) chk_i (.*);

// File: tb/xor_skip_agen_tb_top.sv
`timescale 1ns/1ps
module xor_skip_agen_tb_top;
  localparam int AW = 12;
  localparam int NID = 2;
  localparam int NGRP = 1;
  localparam int K = NID + NGRP;
  localparam int CLK_PERIOD = 10;
  localparam int TOP = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic naive_mode = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] end_addr = '0;
  logic [NID-1:0] unit_id = '0;
  logic [NGRP-1:0] group_id = '0;
  logic [NID*AW-1:0] unit_masks = '0;
  logic [NGRP*AW-1:0] group_masks = '0;
  logic addr_ready = 1'b0;
  logic addr_valid;
  logic [AW-1:0] addr_out;
  logic done;

  int total = 0;
  int bad = 0;
  int got[$];
  int exp_q[$];
  int fast_q[$];
  int max_gap;

  always #(CLK_PERIOD/2) clk = ~clk;

  xor_skip_agen #(.AW(AW), .NID(NID), .NGRP(NGRP)) dut_i (
    .clk(clk), .rst(rst), .start(start), .naive_mode(naive_mode),
    .start_addr(start_addr), .end_addr(end_addr),
    .unit_id(unit_id), .group_id(group_id),
    .unit_masks(unit_masks), .group_masks(group_masks),
    .addr_valid(addr_valid), .addr_ready(addr_ready),
    .addr_out(addr_out), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [AW-1:0] mask_of(input int k);
    if (k < NID) return unit_masks[k*AW +: AW];
    return group_masks[(k-NID)*AW +: AW];
  endfunction

  function automatic bit ids_ok(input int a);
    logic [AW-1:0] av = a[AW-1:0];
    for (int k = 0; k < K; k++) begin
      logic tb = (k < NID) ? unit_id[k] : group_id[k-NID];
      if ((^(av & mask_of(k))) != tb) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic build_expected(input int lo, input int hi);
    exp_q.delete();
    for (int a = lo; a <= hi; a++) begin
      if (ids_ok(a)) exp_q.push_back(a);
    end
  endtask

  task automatic gen_masks();
    int piv[K];
    logic [AW-1:0] pm = '0;
    for (int k = 0; k < K; k++) begin
      int p;
      do p = int'($urandom % (AW - 1)); while (pm[p]);
      piv[k] = p;
      pm[p] = 1'b1;
    end
    for (int k = 0; k < K; k++) begin
      logic [AW-1:0] hi_bits = ~((AW'(1) << (piv[k] + 1)) - AW'(1));
      logic [AW-1:0] m = (AW'(1) << piv[k]) |
                         (AW'($urandom) & AW'($urandom) & hi_bits & ~pm);
      if (k < NID) unit_masks[k*AW +: AW] = m;
      else group_masks[(k-NID)*AW +: AW] = m;
    end
    unit_id = NID'($urandom);
    group_id = NGRP'($urandom);
  endtask

  task automatic run(input int lo, input int hi, input bit nv,
                     input int ready_pct, input bit poke);
    int n = 0;
    int gap = 0;
    bit held = 0;
    logic [AW-1:0] held_addr = '0;
    got.delete();
    max_gap = 0;
    @(negedge clk);
    start_addr = lo[AW-1:0];
    end_addr = hi[AW-1:0];
    naive_mode = nv;
    start = 1'b1;
    addr_ready = 1'b0;
    forever begin
      bit r;
      @(negedge clk);
      start = 1'b0;
      n++;
      if (held) check(addr_valid && addr_out == held_addr, "R5", "held output",
                      int'(addr_out), int'(held_addr));
      if (done) break;
      if (poke && n == 4) begin
        start = 1'b1;
        start_addr = AW'($urandom);
        end_addr = AW'($urandom);
        naive_mode = ~nv;
      end
      if (!addr_valid) gap++; else gap = 0;
      if (gap > max_gap) max_gap = gap;
      r = (int'($urandom % 100) < ready_pct);
      addr_ready = r;
      if (addr_valid && r) got.push_back(int'(addr_out));
      held = addr_valid && !r;
      held_addr = addr_out;
      if (n > 30000) begin
        check(1'b0, "R6", "done never rose", 0, 1);
        break;
      end
    end
    addr_ready = 1'b0;
    start_addr = lo[AW-1:0];
    end_addr = hi[AW-1:0];
    repeat (2) begin
      @(negedge clk);
      check(done && !addr_valid, "R6", "done held, valid low",
            int'({done, addr_valid}), 2);
    end
  endtask

  task automatic compare(input string req);
    check(got.size() == exp_q.size(), req, "sequence length", got.size(), exp_q.size());
    for (int i = 0; i < got.size() && i < exp_q.size(); i++) begin
      check(got[i] == exp_q[i], req, "address", got[i], exp_q[i]);
      check(ids_ok(got[i]), "R2", "identifier parity", got[i], got[i]);
    end
  endtask

  task automatic both_modes(input int lo, input int hi, input int ready_pct);
    build_expected(lo, hi);
    run(lo, hi, 1'b0, ready_pct, 1'b0);
    compare("R3");
    if (ready_pct == 100) check(max_gap <= 3, "R7", "fast gap", max_gap, 3);
    fast_q = got;
    run(lo, hi, 1'b1, ready_pct, 1'b0);
    check(got.size() == fast_q.size(), "R4", "naive length", got.size(), fast_q.size());
    for (int i = 0; i < got.size() && i < fast_q.size(); i++)
      check(got[i] == fast_q[i], "R4", "naive address", got[i], fast_q[i]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "R6", "global watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed_tag;
    seed_tag = $urandom(32'h5eed);
    // Directed masks: bits 4 and 5 feed the same unit bit; pivots 3,4,6.
    unit_masks[0 +: AW] = 12'h108;
    unit_masks[AW +: AW] = 12'h230;
    group_masks[0 +: AW] = 12'h440;
    unit_id = 2'b10;
    group_id = 1'b1;

    repeat (3) @(negedge clk);
    check(!addr_valid && !done, "R1", "in reset", int'({addr_valid, done}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!addr_valid && !done, "R1", "after reset", int'({addr_valid, done}), 0);

    both_modes(0, TOP, 100);

    // R6: start above end yields nothing
    build_expected(100, 50);
    run(100, 50, 1'b0, 100, 1'b0);
    compare("R6");

    // R3: matching start address emitted first, single-address range
    build_expected(0, TOP);
    begin
      int m = exp_q[5];
      build_expected(m, m);
      run(m, m, 1'b0, 100, 1'b0);
      compare("R3");
    end

    // R6: range reaching the top of the space, no wraparound
    both_modes(4000, TOP, 70);

    // R8: start pulse mid-walk ignored
    build_expected(0, 2000);
    run(0, 2000, 1'b0, 60, 1'b1);
    compare("R8");

    for (int it = 0; it < 14; it++) begin
      int lo = int'($urandom % (TOP + 1));
      int len = int'($urandom % 900);
      int hi = (lo + len > TOP) ? TOP : lo + len;
      int pct = (it % 2 == 0) ? 100 : 50;
      gen_masks();
      both_modes(lo, hi, pct);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule